// File: doc/BRIEF.md
# Multi-cycle 16-bit ALU with excess register

This block carries out the two-operand arithmetic, logic, shift, move and conditional-test operations of a small 16-bit processor. A caller presents a 5-bit opcode, the operands B and A, the current value of the excess register (EX) and a skip flag, and pulses `start_i` for one cycle. The block works out the result, the new EX value, a write-back enable and a skip flag for the next instruction. It then holds them back until the operation's cycle budget has elapsed. At that point it raises `done_o` for one cycle.

EX captures the spill of each operation: carry, borrow, the upper half of a product, the fractional part of a quotient, or the bits shifted out. Conditional tests write nothing. A failing test sets the skip flag. When the caller feeds that flag back on the next instruction, that instruction is discarded in one cycle. If the discarded instruction is itself a test, the flag stays set, so a chain of tests is skipped as a group. Operand fetch, write-back and the extended instruction group belong to other blocks.

Top module: `alu16_excess`

## Requirements
- R1: After reset `done_o`, `wr_en_o` and `skip_o` are 0, and `result_o` and `ex_o` are 0x0000.
- R2: When `start_i` is sampled high while the block is idle, `done_o` is high for exactly one cycle, on the N-th rising edge after that sample. N is:
  - 1 for SET 0x01, AND 0x0A, BOR 0x0B, XOR 0x0C, SHR 0x0D, ASR 0x0E and SHL 0x0F;
  - 2 for ADD 0x02, SUB 0x03, MUL 0x04, MLI 0x05, the tests 0x10-0x17, STI 0x1E and STD 0x1F;
  - 3 for DIV 0x06, DVI 0x07, MOD 0x08, MDI 0x09, ADX 0x1A and SBX 0x1B;
  - 1 for any other opcode and for any skipped instruction.
  
  A `start_i` sampled while an operation is in flight is ignored.
- R3: ADD gives (B+A) mod 2^16, and EX becomes 1 if the true sum exceeds 0xFFFF and 0 otherwise. ADX does the same with B+A+EX. Both enable write-back.
- R4: SUB gives (B-A) mod 2^16, and EX becomes 0xFFFF when B<A (unsigned) and 0 otherwise. SBX gives (B-A+EX) mod 2^16, and EX becomes 0xFFFF when B-A+EX is negative and 0 otherwise. Both enable write-back.
- R5: MUL (unsigned) and MLI (signed) put the low 16 bits of the 32-bit product in the result and the high 16 bits in EX, with write-back enabled.
- R6: With A nonzero:
  - DIV gives B/A, and EX becomes bits 15:0 of (B·2^16)/A.
  - DVI does the same with signed operands and truncation toward zero.
  - MOD gives B mod A.
  - MDI gives the signed remainder, which takes the sign of B.
  
  EX is unchanged by MOD and MDI. With A zero, all four give result 0 and leave EX unchanged. All four enable write-back.
- R7: SET, STI and STD give A. AND, BOR and XOR give the bitwise B&A, B|A and B^A. All six enable write-back and leave EX unchanged.
- R8: SHR gives B>>A, and EX becomes bits 15:0 of (B·2^16)>>A. ASR gives B shifted right arithmetically, with the same EX rule. SHL gives B<<A, and EX becomes bits 31:16 of (B<<A). Shifts of 16 or more give 0, except ASR, which gives 0xFFFF or 0x0000 according to bit 15 of B.
- R9: The tests 0x10 (B&A nonzero), 0x11 (B&A zero), 0x12 (B==A), 0x13 (B!=A), 0x14 (B>A unsigned), 0x15 (B>A signed), 0x16 (B<A unsigned) and 0x17 (B<A signed) never enable write-back, give result 0, leave EX unchanged, and set `skip_o` exactly when their condition is false.
- R10: With `skip_i` high the instruction takes one cycle, does not enable write-back, gives result 0 and leaves EX unchanged. `skip_o` is 1 only if the opcode is in 0x10-0x17.
- R11: An opcode outside the list above (for example 0x00, 0x18, 0x19, 0x1C, 0x1D) does not enable write-back, gives result 0, leaves EX unchanged and clears `skip_o`. Every executed non-test instruction also clears `skip_o`.
- R12: `result_o`, `ex_o`, `wr_en_o` and `skip_o` change only on the edge that raises `done_o`, and hold their values until the next such edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an operation with the inputs present in this cycle |
| op_i | input | 5 | Operation code |
| b_i | input | 16 | Operand B (destination-side operand) |
| a_i | input | 16 | Operand A (source-side operand) |
| ex_i | input | 16 | Current excess register value |
| skip_i | input | 1 | Discard this instruction |
| result_o | output | 16 | Operation result |
| ex_o | output | 16 | New excess register value |
| wr_en_o | output | 1 | Result must be written back |
| skip_o | output | 1 | Next instruction must be skipped |
| done_o | output | 1 | One-cycle pulse marking valid outputs |

## Verification
The hardest behaviour to reach from the ports is the skip chain. A failing test must be followed by further tests and then a non-test instruction, all with `skip_i` set. The bench builds this by feeding back the `skip_o` value of each completed operation as the `skip_i` of the next one, over a run of consecutive tests. It then checks that the flag survives every test and drops on the first ordinary instruction.

The signed divide corners are also driven on purpose: a negative dividend, the most negative value over -1, and zero divisors. So is the start pulse issued while a three-cycle divide is still counting, which must be ignored.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  typedef enum logic [4:0] {
    OP_SET = 5'h01, OP_ADD = 5'h02, OP_SUB = 5'h03, OP_MUL = 5'h04,
    OP_MLI = 5'h05, OP_DIV = 5'h06, OP_DVI = 5'h07, OP_MOD = 5'h08,
    OP_MDI = 5'h09, OP_AND = 5'h0A, OP_BOR = 5'h0B, OP_XOR = 5'h0C,
    OP_SHR = 5'h0D, OP_ASR = 5'h0E, OP_SHL = 5'h0F,
    OP_TBS = 5'h10, OP_TBC = 5'h11, OP_TEQ = 5'h12, OP_TNE = 5'h13,
    OP_TGU = 5'h14, OP_TGS = 5'h15, OP_TLU = 5'h16, OP_TLS = 5'h17,
    OP_ADX = 5'h1A, OP_SBX = 5'h1B, OP_STI = 5'h1E, OP_STD = 5'h1F
  } alu_op_e;

  // conditional tests occupy 0x10..0x17
  function automatic logic is_test(input logic [4:0] op);
    return op[4:3] == 2'b10;
  endfunction

endpackage

// File: rtl/alu16_core.sv
module alu16_core
  import alu16_pkg::*;
#(
  parameter int W     = 16,
  parameter int CNT_W = 2
) (
  input  logic [4:0]       op_i,
  input  logic [W-1:0]     b_i,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     ex_i,
  input  logic             skip_i,
  output logic [W-1:0]     res_o,
  output logic [W-1:0]     ex_o,
  output logic             wr_o,
  output logic             skip_o,
  output logic [CNT_W-1:0] cyc_o
);

  localparam int W2 = 2 * W;
  localparam int W3 = 3 * W;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  // add / subtract with and without excess
  logic [W:0]   add_s;
  logic [W+1:0] adx_s;
  logic [W:0]   sub_d;
  logic [W+2:0] sbx_d;
  assign add_s = {1'b0, b_i} + {1'b0, a_i};
  assign adx_s = {2'b0, b_i} + {2'b0, a_i} + {2'b0, ex_i};
  assign sub_d = {1'b0, b_i} - {1'b0, a_i};
  assign sbx_d = {3'b0, b_i} - {3'b0, a_i} + {3'b0, ex_i};

  // products
  logic [W2-1:0]        mul_u;
  logic signed [W2-1:0] mul_s;
  assign mul_u = {{W{1'b0}}, b_i} * {{W{1'b0}}, a_i};
  assign mul_s = $signed({{W{b_i[W-1]}}, b_i}) * $signed({{W{a_i[W-1]}}, a_i});

  // quotients; a zero divisor is replaced so no undefined value appears
  logic                 a_zero;
  logic [W-1:0]         a_safe;
  logic [W-1:0]         qu_lo, fu_lo, mu_lo, qs_lo, fs_lo, ms_lo;
  logic signed [W3-1:0] sb3, sa3;
  assign a_zero = (a_i == '0);
  assign a_safe = a_zero ? W'(1) : a_i;
  assign qu_lo  = b_i / a_safe;
  assign fu_lo  = W'({b_i, {W{1'b0}}} / {{W{1'b0}}, a_safe});
  assign mu_lo  = b_i % a_safe;
  assign sb3    = $signed({{W2{b_i[W-1]}}, b_i});
  assign sa3    = $signed({{W2{a_safe[W-1]}}, a_safe});
  assign qs_lo  = W'(sb3 / sa3);
  assign fs_lo  = W'((sb3 <<< W) / sa3);
  assign ms_lo  = W'(sb3 % sa3);

  // shifts; out-of-range amounts fall out of the wide shifters naturally
  logic [W2-1:0] shr_w, shl_w;
  logic [W-1:0]  shr_r, asr_r;
  assign shr_w = {b_i, {W{1'b0}}} >> a_i;
  assign shl_w = {{W{1'b0}}, b_i} << a_i;
  assign shr_r = b_i >> a_i;
  assign asr_r = W'($signed(b_i) >>> a_i);

  // conditional tests: cond true means execute the next instruction
  logic cond;
  always_comb begin
    case (op_i[2:0])
      3'd0:    cond = (b_i & a_i) != '0;
      3'd1:    cond = (b_i & a_i) == '0;
      3'd2:    cond = b_i == a_i;
      3'd3:    cond = b_i != a_i;
      3'd4:    cond = b_i > a_i;
      3'd5:    cond = $signed(b_i) > $signed(a_i);
      3'd6:    cond = b_i < a_i;
      default: cond = $signed(b_i) < $signed(a_i);
    endcase
  end

  always_comb begin
    res_o  = '0;
    ex_o   = ex_i;
    wr_o   = 1'b0;
    skip_o = 1'b0;
    cyc_o  = CNT_W'(1);
    if (skip_i) begin
      skip_o = is_test(op_i);
    end else if (is_test(op_i)) begin
      skip_o = !cond;
      cyc_o  = CNT_W'(2);
    end else begin
      wr_o = 1'b1;
      case (op_i)
        OP_SET, OP_STI, OP_STD: begin
          res_o = a_i;
          if (op_i != OP_SET) cyc_o = CNT_W'(2);
        end
        OP_ADD: begin
          res_o = add_s[W-1:0];
          ex_o  = add_s[W] ? W'(1) : '0;
          cyc_o = CNT_W'(2);
        end
        OP_ADX: begin
          res_o = adx_s[W-1:0];
          ex_o  = (adx_s[W+1:W] != 2'b00) ? W'(1) : '0;
          cyc_o = CNT_W'(3);
        end
        OP_SUB: begin
          res_o = sub_d[W-1:0];
          ex_o  = sub_d[W] ? ONES : '0;
          cyc_o = CNT_W'(2);
        end
        OP_SBX: begin
          res_o = sbx_d[W-1:0];
          ex_o  = sbx_d[W+2] ? ONES : '0;
          cyc_o = CNT_W'(3);
        end
        OP_MUL: begin
          res_o = mul_u[W-1:0];
          ex_o  = mul_u[W2-1:W];
          cyc_o = CNT_W'(2);
        end
        OP_MLI: begin
          res_o = mul_s[W-1:0];
          ex_o  = mul_s[W2-1:W];
          cyc_o = CNT_W'(2);
        end
        OP_DIV, OP_DVI: begin
          cyc_o = CNT_W'(3);
          if (!a_zero) begin
            res_o = (op_i == OP_DIV) ? qu_lo : qs_lo;
            ex_o  = (op_i == OP_DIV) ? fu_lo : fs_lo;
          end
        end
        OP_MOD, OP_MDI: begin
          cyc_o = CNT_W'(3);
          if (!a_zero) res_o = (op_i == OP_MOD) ? mu_lo : ms_lo;
        end
        OP_AND: res_o = b_i & a_i;
        OP_BOR: res_o = b_i | a_i;
        OP_XOR: res_o = b_i ^ a_i;
        OP_SHR: begin
          res_o = shr_r;
          ex_o  = shr_w[W-1:0];
        end
        OP_ASR: begin
          res_o = asr_r;
          ex_o  = shr_w[W-1:0];
        end
        OP_SHL: begin
          res_o = shl_w[W-1:0];
          ex_o  = shl_w[W2-1:W];
        end
        default: wr_o = 1'b0;
      endcase
    end
  end

  always_comb begin
    AST_SKIP_SILENT: assert (!(skip_i && (wr_o || cyc_o != CNT_W'(1)))); // R10
    AST_TEST_NO_WRITE: assert (!(is_test(op_i) && wr_o)); // R9
    AST_DIV_ZERO: assert (!(!skip_i && a_zero && op_i >= 5'h06 && op_i <= 5'h09 && res_o != '0)); // R6
  end

endmodule

// File: rtl/alu16_seq.sv
module alu16_seq #(
  parameter int W     = 16,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [W-1:0]     res_i,
  input  logic [W-1:0]     ex_i,
  input  logic             wr_i,
  input  logic             skip_i,
  input  logic [CNT_W-1:0] cyc_i,
  output logic [W-1:0]     res_o,
  output logic [W-1:0]     ex_o,
  output logic             wr_o,
  output logic             skip_o,
  output logic             done_o
);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0]     pres_q, pex_q;
  logic             pwr_q, pskip_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      pres_q  <= '0;
      pex_q   <= '0;
      pwr_q   <= 1'b0;
      pskip_q <= 1'b0;
      res_o   <= '0;
      ex_o    <= '0;
      wr_o    <= 1'b0;
      skip_o  <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q  <= 1'b1;
          cnt_q   <= cyc_i;
          pres_q  <= res_i;
          pex_q   <= ex_i;
          pwr_q   <= wr_i;
          pskip_q <= skip_i;
        end
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          res_o  <= pres_q;
          ex_o   <= pex_q;
          wr_o   <= pwr_q;
          skip_o <= pskip_q;
          done_o <= 1'b1;
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R2
  AST_BUSY_COUNT: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> cnt_q != '0); // R2
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(res_o) && $stable(ex_o) && $stable(wr_o) && $stable(skip_o))); // R12

endmodule

// File: rtl/alu16_excess.sv
module alu16_excess #(
  parameter int W     = 16,
  parameter int OP_W  = 5,
  parameter int CNT_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_i,
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    b_i,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    ex_i,
  input  logic            skip_i,
  output logic [W-1:0]    result_o,
  output logic [W-1:0]    ex_o,
  output logic            wr_en_o,
  output logic            skip_o,
  output logic            done_o
);

  logic [W-1:0]     c_res, c_ex;
  logic             c_wr, c_skip;
  logic [CNT_W-1:0] c_cyc;

  alu16_core #(.W(W), .CNT_W(CNT_W)) u_core (
    .op_i   (5'(op_i)),
    .b_i    (b_i),
    .a_i    (a_i),
    .ex_i   (ex_i),
    .skip_i (skip_i),
    .res_o  (c_res),
    .ex_o   (c_ex),
    .wr_o   (c_wr),
    .skip_o (c_skip),
    .cyc_o  (c_cyc)
  );

  alu16_seq #(.W(W), .CNT_W(CNT_W)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .res_i   (c_res),
    .ex_i    (c_ex),
    .wr_i    (c_wr),
    .skip_i  (c_skip),
    .cyc_i   (c_cyc),
    .res_o   (result_o),
    .ex_o    (ex_o),
    .wr_o    (wr_en_o),
    .skip_o  (skip_o),
    .done_o  (done_o)
  );

endmodule

// File: tb/alu16_excess_bench.sv
module alu16_excess_bench;

  typedef struct {
    logic [15:0] res;
    logic [15:0] ex;
    logic        wr;
    logic        sk;
    int          n;
    int          t0;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [4:0]  op_i = '0;
  logic [15:0] b_i = '0, a_i = '0, ex_i = '0;
  logic        skip_i = 1'b0;
  logic [15:0] result_o, ex_o;
  logic        wr_en_o, skip_o, done_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int extra = 0;
  logic last_skip = 1'b0;
  exp_t q[$];

  alu16_excess u_alu16_excess (
    .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .b_i(b_i),
    .a_i(a_i), .ex_i(ex_i), .skip_i(skip_i), .result_o(result_o),
    .ex_o(ex_o), .wr_en_o(wr_en_o), .skip_o(skip_o), .done_o(done_o)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic exp_t model(input logic [4:0] op, input logic [15:0] b,
                                 input logic [15:0] a, input logic [15:0] ex,
                                 input logic sk);
    exp_t e;
    longint ub = longint'(b), ua = longint'(a), ue = longint'(ex), t;
    longint sb = longint'($signed(b)), sa = longint'($signed(a));
    e.res = 16'h0; e.ex = ex; e.wr = 1'b0; e.sk = 1'b0; e.n = 1;
    if (sk) begin
      e.sk = (op >= 5'h10 && op <= 5'h17);
      return e;
    end
    if (op >= 5'h10 && op <= 5'h17) begin
      logic c;
      case (op)
        5'h10: c = (b & a) != 0;
        5'h11: c = (b & a) == 0;
        5'h12: c = b == a;
        5'h13: c = b != a;
        5'h14: c = ub > ua;
        5'h15: c = sb > sa;
        5'h16: c = ub < ua;
        default: c = sb < sa;
      endcase
      e.sk = !c; e.n = 2;
      return e;
    end
    e.wr = 1'b1;
    case (op)
      5'h01: e.res = a;
      5'h1E, 5'h1F: begin e.res = a; e.n = 2; end
      5'h02: begin t = ub + ua; e.res = 16'(t); e.ex = (t > 65535) ? 16'd1 : 16'd0; e.n = 2; end
      5'h1A: begin t = ub + ua + ue; e.res = 16'(t); e.ex = (t > 65535) ? 16'd1 : 16'd0; e.n = 3; end
      5'h03: begin t = ub - ua; e.res = 16'(t); e.ex = (t < 0) ? 16'hFFFF : 16'h0; e.n = 2; end
      5'h1B: begin t = ub - ua + ue; e.res = 16'(t); e.ex = (t < 0) ? 16'hFFFF : 16'h0; e.n = 3; end
      5'h04: begin t = ub * ua; e.res = 16'(t); e.ex = 16'(t >> 16); e.n = 2; end
      5'h05: begin t = sb * sa; e.res = 16'(t); e.ex = 16'(t >>> 16); e.n = 2; end
      5'h06: begin e.n = 3; if (a != 0) begin e.res = 16'(ub / ua); e.ex = 16'((ub * 65536) / ua); end end
      5'h07: begin e.n = 3; if (a != 0) begin e.res = 16'(sb / sa); e.ex = 16'((sb * 65536) / sa); end end
      5'h08: begin e.n = 3; if (a != 0) e.res = 16'(ub % ua); end
      5'h09: begin e.n = 3; if (a != 0) e.res = 16'(sb % sa); end
      5'h0A: e.res = b & a;
      5'h0B: e.res = b | a;
      5'h0C: e.res = b ^ a;
      5'h0D, 5'h0E: begin
        if (op == 5'h0D) e.res = (ua >= 16) ? 16'h0 : 16'(ub >> ua);
        else e.res = (ua >= 16) ? {16{b[15]}} : 16'(sb >>> ua);
        e.ex = (ua >= 32) ? 16'h0 : 16'((ub * 65536) >> ua);
      end
      5'h0F: begin
        e.res = (ua >= 16) ? 16'h0 : 16'(ub << ua);
        e.ex  = (ua >= 32) ? 16'h0 : 16'((ub << ua) >> 16);
      end
      default: e.wr = 1'b0;
    endcase
    return e;
  endfunction

  task automatic issue(input logic [4:0] op, input logic [15:0] b, input logic [15:0] a,
                       input logic [15:0] ex, input logic sk, input string tag);
    exp_t e;
    @(negedge clk);
    e = model(op, b, a, ex, sk);
    e.t0 = cyc + 1;
    e.tag = tag;
    q.push_back(e);
    op_i = op; b_i = b; a_i = a; ex_i = ex; skip_i = sk; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic run_op(input logic [4:0] op, input logic [15:0] b, input logic [15:0] a,
                        input logic [15:0] ex, input logic sk, input string tag);
    issue(op, b, a, ex, sk, tag);
    while (q.size() != 0) @(negedge clk);
  endtask

  // monitor: pops expected items as done pulses appear
  always @(negedge clk) begin
    if (!rst && done_o) begin
      last_skip = skip_o;
      if (q.size() == 0) begin
        extra++;
      end else begin
        exp_t e;
        e = q.pop_front();
        total++;
        if (result_o !== e.res || ex_o !== e.ex || wr_en_o !== e.wr ||
            skip_o !== e.sk || (cyc - e.t0) != e.n) begin
          bad++;
          $display("FAIL %s: res=%h ex=%h wr=%b sk=%b n=%0d expected res=%h ex=%h wr=%b sk=%b n=%0d",
                   e.tag, result_o, ex_o, wr_en_o, skip_o, cyc - e.t0,
                   e.res, e.ex, e.wr, e.sk, e.n);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    total++;
    if (done_o !== 1'b0 || wr_en_o !== 1'b0 || skip_o !== 1'b0 ||
        result_o !== 16'h0 || ex_o !== 16'h0) begin
      bad++;
      $display("FAIL R1: done=%b wr=%b sk=%b res=%h ex=%h expected all zero",
               done_o, wr_en_o, skip_o, result_o, ex_o);
    end

    // R3 add family
    run_op(5'h02, 16'h1234, 16'h0001, 16'h5555, 1'b0, "R3 add no carry");
    run_op(5'h02, 16'hFFFF, 16'h0002, 16'h0000, 1'b0, "R3 add carry");
    run_op(5'h1A, 16'hFFFE, 16'h0001, 16'h0001, 1'b0, "R3 adx carry via ex");
    run_op(5'h1A, 16'h0010, 16'h0020, 16'h0003, 1'b0, "R3 adx plain");
    // R4 subtract family
    run_op(5'h03, 16'h0005, 16'h0003, 16'h1111, 1'b0, "R4 sub");
    run_op(5'h03, 16'h0003, 16'h0005, 16'h0000, 1'b0, "R4 sub borrow");
    run_op(5'h1B, 16'h0003, 16'h0005, 16'h0001, 1'b0, "R4 sbx borrow");
    run_op(5'h1B, 16'h0003, 16'h0005, 16'h0002, 1'b0, "R4 sbx zero");
    // R5 multiply
    run_op(5'h04, 16'hFFFF, 16'hFFFF, 16'h0000, 1'b0, "R5 mul");
    run_op(5'h05, 16'hFFFE, 16'h0003, 16'h0000, 1'b0, "R5 mli negative");
    // R6 divide / modulo
    run_op(5'h06, 16'h0007, 16'h0002, 16'h0000, 1'b0, "R6 div");
    run_op(5'h06, 16'h1234, 16'h0000, 16'hABCD, 1'b0, "R6 div by zero");
    run_op(5'h07, 16'hFFF9, 16'h0002, 16'h0000, 1'b0, "R6 dvi negative");
    run_op(5'h07, 16'h8000, 16'hFFFF, 16'h0000, 1'b0, "R6 dvi min by -1");
    run_op(5'h08, 16'h0011, 16'h0005, 16'h7777, 1'b0, "R6 mod");
    run_op(5'h08, 16'h0011, 16'h0000, 16'h7777, 1'b0, "R6 mod by zero");
    run_op(5'h09, 16'hFFF9, 16'h0010, 16'h0000, 1'b0, "R6 mdi negative");
    run_op(5'h09, 16'hFFF9, 16'h0000, 16'h0042, 1'b0, "R6 mdi by zero");
    // R7 moves and logic
    run_op(5'h01, 16'h1111, 16'hBEEF, 16'h0042, 1'b0, "R7 set");
    run_op(5'h1E, 16'h0000, 16'h00A5, 16'h0042, 1'b0, "R7 sti");
    run_op(5'h1F, 16'h0000, 16'h005A, 16'h0042, 1'b0, "R7 std");
    run_op(5'h0A, 16'hF0F0, 16'h3C3C, 16'h0042, 1'b0, "R7 and");
    run_op(5'h0B, 16'hF0F0, 16'h3C3C, 16'h0042, 1'b0, "R7 bor");
    run_op(5'h0C, 16'hF0F0, 16'h3C3C, 16'h0042, 1'b0, "R7 xor");
    // R8 shifts
    run_op(5'h0D, 16'h8421, 16'h0004, 16'h0000, 1'b0, "R8 shr");
    run_op(5'h0D, 16'h8421, 16'h0014, 16'h0000, 1'b0, "R8 shr 20");
    run_op(5'h0E, 16'h8421, 16'h0004, 16'h0000, 1'b0, "R8 asr");
    run_op(5'h0E, 16'h8421, 16'h0011, 16'h0000, 1'b0, "R8 asr 17");
    run_op(5'h0E, 16'h4000, 16'h0020, 16'h0000, 1'b0, "R8 asr positive 32");
    run_op(5'h0F, 16'h8421, 16'h0004, 16'h0000, 1'b0, "R8 shl");
    run_op(5'h0F, 16'h8421, 16'h0018, 16'h0000, 1'b0, "R8 shl 24");
    // R9 tests, each both ways
    for (int k = 0; k < 8; k++) begin
      run_op(5'(16 + k), 16'h00F0, 16'h0010, 16'h0042, 1'b0, "R9 test pattern 1");
      run_op(5'(16 + k), 16'hFFFF, 16'h0001, 16'h0042, 1'b0, "R9 test pattern 2");
      run_op(5'(16 + k), 16'h0003, 16'h0003, 16'h0042, 1'b0, "R9 test equal");
    end
    // R10 chained skip: failing test, then tests and an ordinary op fed by skip_o
    run_op(5'h12, 16'h0001, 16'h0002, 16'h0000, 1'b0, "R10 chain head");
    run_op(5'h13, 16'h0001, 16'h0001, 16'h0000, last_skip, "R10 chained test 1");
    run_op(5'h16, 16'h0009, 16'h0001, 16'h0000, last_skip, "R10 chained test 2");
    run_op(5'h02, 16'h0001, 16'h0001, 16'h0033, last_skip, "R10 skipped add");
    run_op(5'h06, 16'h0008, 16'h0002, 16'h0033, 1'b1, "R10 skipped div one cycle");
    // R11 unknown opcodes and skip clearing
    run_op(5'h00, 16'h1234, 16'h5678, 16'h0099, 1'b0, "R11 op 0x00");
    run_op(5'h18, 16'h1234, 16'h5678, 16'h0099, 1'b0, "R11 op 0x18");
    run_op(5'h1D, 16'h1234, 16'h5678, 16'h0099, 1'b0, "R11 op 0x1D");
    // R2 start while busy is ignored
    issue(5'h06, 16'h0064, 16'h0007, 16'h0000, 1'b0, "R2 div during busy");
    op_i = 5'h01; a_i = 16'hDEAD; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (q.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
    total++;
    if (extra != 0) begin
      bad++;
      $display("FAIL R2: unexpected done pulses=%0d expected 0", extra);
    end
    // R12 outputs hold after done
    begin
      logic [15:0] hr, he;
      hr = result_o; he = ex_o;
      op_i = 5'h0C; b_i = 16'hFFFF; a_i = 16'h0F0F;
      repeat (4) @(negedge clk);
      total++;
      if (result_o !== hr || ex_o !== he) begin
        bad++;
        $display("FAIL R12: res=%h ex=%h expected res=%h ex=%h", result_o, ex_o, hr, he);
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule